// File: doc/BRIEF.md
# Configuration File Header Stripper

This block sits on a byte stream (valid/ready) that carries a raw device configuration file. Its job is to drop everything in front of the configuration payload and pass on only the payload to the sequencer that follows. The start of the file is a region of fixed size. After it come a set of text fields, and each field has a length prefix. The block walks these fields by reading each length byte. It does not assume a fixed header size. Once the last field has been skipped, it examines the stream one byte at a time for a run of four all-ones bytes. That run is the synchronization preamble.

When the run is found, the block sends the four preamble bytes downstream and then passes the rest of the file through unchanged, including the end marker on the last byte. It also reports the file offset at which the preamble began. If the file ends before a preamble appears, the block raises an error flag and forwards nothing. After any file ends, the block is ready to parse the next file from offset zero, with no reset needed.

Top module: `cfg_stream_trim`

## Requirements
- R1: After reset, in_ready is 1 and out_valid, start_valid and no_preamble are 0.
- R2: The bytes at file offsets 0 to 14 are discarded unread. The byte at offset 15 is taken as the first field length.
- R3: Exactly four fields are skipped. When a field's length byte L sits at offset p, the next field length (or, after the fourth field, the first scanned byte) sits at offset p+L+3. None of these bytes is forwarded.
- R4: After the fourth field, the scan looks for four consecutive 0xFF bytes. Any byte other than 0xFF restarts the count.
- R5: A run longer than four 0xFF bytes matches at its first byte. For example, six 0xFF bytes in a row give the offset of the first of them.
- R6: The forwarded stream is exactly the file bytes from the first preamble byte to the last file byte, in order. It starts with four 0xFF bytes.
- R7: When the match is found, start_valid rises. At the same moment start_offset takes the file offset of the first preamble byte, and the first preamble byte is offered on the output.
- R8: If the file ends before a preamble completes, including when it ends inside the header, no_preamble is raised, no byte is forwarded, and start_valid stays 0.
- R9: out_last is 1 only on the final forwarded byte, which is the file's last byte. This includes the case where the last preamble byte ends the file.
- R10: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data and out_last stay unchanged.
- R11: 0xFF bytes inside the fixed region or inside field bodies never count toward the preamble.
- R12: After a file's last byte, the next byte starts a new file at offset 0. start_valid, start_offset and no_preamble hold their values until the first byte of the next file is accepted, and then start_valid and no_preamble clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | File byte |
| in_valid | input | 1 | in_data holds a byte |
| in_last | input | 1 | Byte is the last of the file |
| in_ready | output | 1 | Block accepts the byte this cycle |
| out_data | output | 8 | Payload byte |
| out_valid | output | 1 | out_data holds a payload byte |
| out_last | output | 1 | Payload byte is the last of the file |
| out_ready | input | 1 | Downstream accepts the byte this cycle |
| start_offset | output | OFFW | File offset of the first preamble byte |
| start_valid | output | 1 | A preamble was found in the current or most recent file |
| no_preamble | output | 1 | The most recent file ended without a preamble |

## Verification
Payload bytes after the preamble pass through combinationally, so they appear in the same cycle as the input byte. The first preamble byte and start_valid appear one cycle after the byte that completed the match is accepted. no_preamble appears one cycle after the last file byte is accepted. The bench drives inputs on the falling edge and records each handshake on both sides 1 ns later, which is before the rising edge that completes it. It compares the flags and the offset only after the stream has gone idle. The stall checks compare each held output with the value it had on the falling edge before.

// File: rtl/cfg_stream_trim.sv
module cfg_stream_trim #(
  parameter int         HDR_START = 15,
  parameter int         FIELDS    = 4,
  parameter int         FIELD_GAP = 3,
  parameter int         PRE_LEN   = 4,
  parameter logic [7:0] PRE_BYTE  = 8'hFF,
  parameter int         OFFW      = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      in_data,
  input  logic            in_valid,
  input  logic            in_last,
  output logic            in_ready,
  output logic [7:0]      out_data,
  output logic            out_valid,
  output logic            out_last,
  input  logic            out_ready,
  output logic [OFFW-1:0] start_offset,
  output logic            start_valid,
  output logic            no_preamble
);
  localparam int FCW  = $clog2(FIELDS + 1);
  localparam int RUNW = $clog2(PRE_LEN + 1);
  localparam int SKW  = ($clog2(HDR_START + 1) > 10) ? $clog2(HDR_START + 1) : 10;

  typedef enum logic [1:0] {HDR, SCAN, EMIT, PASS} st_t;

  st_t            st;
  logic [SKW-1:0] skip_left;
  logic [FCW-1:0] fields;
  logic [RUNW-1:0] run;
  logic [RUNW-1:0] emit_left;
  logic           last_pend;
  logic [OFFW-1:0] byte_idx;

  wire take  = in_valid && in_ready;
  wire pop   = out_valid && out_ready;
  wire is_pre = in_data == PRE_BYTE;
  wire hit   = is_pre && (run == RUNW'(PRE_LEN - 1));

  assign in_ready  = (st == HDR || st == SCAN) ? 1'b1 : (st == PASS) ? out_ready : 1'b0;
  assign out_valid = (st == EMIT) || (st == PASS && in_valid);
  assign out_data  = (st == PASS) ? in_data : PRE_BYTE;
  assign out_last  = (st == PASS) ? in_last : (last_pend && emit_left == RUNW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= HDR;
      skip_left    <= SKW'(HDR_START);
      fields       <= '0;
      run          <= '0;
      emit_left    <= '0;
      last_pend    <= 1'b0;
      byte_idx     <= '0;
      start_offset <= '0;
      start_valid  <= 1'b0;
      no_preamble  <= 1'b0;
    end else begin
      case (st)
        HDR: if (take) begin
          byte_idx <= byte_idx + 1'b1;
          if (byte_idx == '0) begin
            start_valid <= 1'b0;
            no_preamble <= 1'b0;
          end
          if (skip_left != '0) begin
            skip_left <= skip_left - 1'b1;
            if (skip_left == SKW'(1) && fields == FCW'(FIELDS)) begin
              st  <= SCAN;
              run <= '0;
            end
          end else begin
            skip_left <= SKW'(in_data) + SKW'(FIELD_GAP - 1);
            fields    <= fields + 1'b1;
          end
          if (in_last) begin
            no_preamble <= 1'b1;
            st          <= HDR;
            skip_left   <= SKW'(HDR_START);
            fields      <= '0;
            byte_idx    <= '0;
          end
        end
        SCAN: if (take) begin
          byte_idx <= byte_idx + 1'b1;
          if (hit) begin
            start_offset <= byte_idx - OFFW'(PRE_LEN - 1);
            start_valid  <= 1'b1;
            emit_left    <= RUNW'(PRE_LEN);
            last_pend    <= in_last;
            st           <= EMIT;
          end else begin
            run <= is_pre ? run + 1'b1 : '0;
            if (in_last) begin
              no_preamble <= 1'b1;
              st          <= HDR;
              skip_left   <= SKW'(HDR_START);
              fields      <= '0;
              byte_idx    <= '0;
            end
          end
        end
        EMIT: if (pop) begin
          emit_left <= emit_left - 1'b1;
          if (emit_left == RUNW'(1)) begin
            st        <= last_pend ? HDR : PASS;
            skip_left <= SKW'(HDR_START);
            fields    <= '0;
            byte_idx  <= '0;
          end
        end
        PASS: if (pop && in_last) st <= HDR;
        default: st <= HDR;
      endcase
    end
  end

  // R10
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R7
  first_pre_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_valid) |-> out_valid && out_data == PRE_BYTE);

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_valid && no_preamble));

  // R8
  err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_preamble) |-> !out_valid);

  // R9
  last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);
endmodule

// File: tb/cfg_stream_trim_test.sv
module cfg_stream_trim_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_last, start_valid, no_preamble;
  logic [7:0] out_data;
  logic [31:0] start_offset;

  always #2 clk = ~clk;

  cfg_stream_trim uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
    .out_ready(out_ready), .start_offset(start_offset), .start_valid(start_valid),
    .no_preamble(no_preamble));

  int n_chk = 0, n_bad = 0, cyc = 0, nfiles = 0;
  logic [7:0] fb [0:1023];
  logic [7:0] ob [0:1023];
  logic       ol [0:1023];
  int flen;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic put(logic [7:0] b); fb[flen] = b; flen++; endtask
  task automatic put_ff(int n); for (int i = 0; i < n; i++) put(8'hFF); endtask
  task automatic put_noff(int n); for (int i = 0; i < n; i++) put(8'($urandom_range(0, 254))); endtask
  task automatic put_mix(int n);
    for (int i = 0; i < n; i++) put(($urandom % 10 < 3) ? 8'hFF : 8'($urandom));
  endtask

  task automatic hdr(bit ff, int lmax);
    flen = 0;
    if (ff) put_ff(15); else put_noff(15);
    for (int k = 0; k < 4; k++) begin
      int l = $urandom_range(0, lmax);
      put(8'(l));
      if (ff) put_ff(l + 2); else put_noff(l + 2);
    end
  endtask

  function automatic int exp_offset();
    int p = 15;
    for (int k = 0; k < 4; k++) begin
      if (p >= flen) return -1;
      p = p + int'(fb[p]) + 3;
    end
    for (int i = p; i + 3 < flen; i++)
      if (fb[i] == 8'hFF && fb[i+1] == 8'hFF && fb[i+2] == 8'hFF && fb[i+3] == 8'hFF) return i;
    return -1;
  endfunction

  task automatic run_file(string tag);
    int eo = exp_offset();
    int idx = 0, nout = 0, idle = 0, bad_at;
    bit took = 0, pv = 0, pr = 0, pl = 0, clr_pending = 0;
    logic [7:0] pd = '0;
    while (idle < 12) begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        chk(0, tag, "watchdog expired", cyc, 150000);
        finish_run();
      end
      if (clr_pending) begin
        chk(!start_valid && !no_preamble, "R12", "flags clear after first byte",
            {start_valid, no_preamble}, 0);
        clr_pending = 0;
      end
      if (in_valid && took) in_valid = 0;
      if (!in_valid && idx < flen && $urandom % 10 < 7) begin
        in_valid = 1; in_data = fb[idx]; in_last = (idx == flen - 1);
      end
      out_ready = ($urandom % 4) != 0;
      #1;
      if (pv && !pr)
        chk(out_valid && out_data == pd && out_last == pl, "R10", "output held in stall",
            {out_valid, out_data, out_last}, {1'b1, pd, pl});
      took = in_valid && in_ready;
      if (took) begin
        if (idx == 0 && nfiles > 0) clr_pending = 1;
        idx++;
      end
      if (out_valid && out_ready) begin
        ob[nout] = out_data; ol[nout] = out_last; nout++;
      end
      pv = out_valid; pr = out_ready; pd = out_data; pl = out_last;
      if (idx == flen && !in_valid) idle++;
    end
    in_valid = 0;
    nfiles++;
    if (eo < 0) begin
      chk(no_preamble == 1, tag, "R8 no_preamble set", no_preamble, 1);
      chk(start_valid == 0, tag, "R8 start_valid low", start_valid, 0);
      chk(nout == 0, tag, "R8 nothing forwarded", nout, 0);
    end else begin
      chk(start_valid == 1 && no_preamble == 0, tag, "R7 start_valid set", {start_valid, no_preamble}, 2);
      chk(start_offset == 32'(eo), tag, "R7 R2 R3 start_offset", start_offset, eo);
      chk(nout == flen - eo, tag, "R6 payload length", nout, flen - eo);
      bad_at = -1;
      for (int i = 0; i < nout && i < flen - eo; i++)
        if (bad_at < 0 && ob[i] !== fb[eo + i]) bad_at = i;
      chk(bad_at < 0, tag, "R6 payload byte", (bad_at < 0) ? 0 : ob[bad_at], (bad_at < 0) ? 0 : fb[eo + bad_at]);
      bad_at = -1;
      for (int i = 0; i < nout; i++)
        if (bad_at < 0 && ol[i] !== (i == nout - 1)) bad_at = i;
      chk(bad_at < 0, tag, "R9 last marker position", bad_at, -1);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    chk(start_valid == 0 && no_preamble == 0, "R1", "flags after reset", {start_valid, no_preamble}, 0);

    flen = 0; put_noff(15);
    put(8'd0); put_noff(2); put(8'd5); put_noff(7); put(8'd2); put_noff(4); put(8'd9); put_noff(11);
    put_noff(3); put_ff(4); put_noff(20);
    run_file("R2_R3");

    hdr(1, 6); put(8'h00); put(8'h12); put_ff(4); put_mix(15);
    run_file("R11");

    hdr(0, 5); put_noff(4); put_ff(6); put_mix(10);
    run_file("R5");

    hdr(0, 5); put(8'hFF); put(8'hFF); put(8'hFF); put(8'h00); put(8'hFF); put(8'hFF); put(8'h33);
    put_ff(4); put_noff(8);
    run_file("R4");

    hdr(0, 5); put_noff(30);
    run_file("R8_scan");

    hdr(0, 5); put_noff(5); put_ff(4);
    run_file("R9_end");

    flen = 0; put_noff(10);
    run_file("R8_short");

    hdr(0, 3); put_ff(4); put_noff(6);
    run_file("R3_tight");

    for (int f = 0; f < 14; f++) begin
      hdr($urandom % 5 == 0, 12);
      put_mix($urandom_range(0, 25));
      if ($urandom % 6 != 0) put_ff($urandom_range(4, 7));
      put_mix($urandom_range(0, 60));
      run_file("R6_rand");
    end
    finish_run();
  end
endmodule